// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block merges the five interrupt sources of a serial port into a single interrupt request and an identification byte. The sources are a receive line error, receive data at its trigger level, a receive character timeout, an empty transmit holding stage and a change on the modem status lines. Each source has its own enable bit. The identification byte names only the most urgent enabled source that is pending, using a fixed 4-bit code. When nothing is pending, bit 0 of the byte is 1.

The five source conditions arrive from elsewhere as levels, except the transmit side, which arrives as a one-cycle "holding stage just went empty" event. The block keeps its own pending flag for the transmit-empty interrupt. That flag is cleared when software reads an identification byte that reports transmit-empty, or when software writes new data into the holding register. The interrupt pin is only driven while the output-2 control bit is 1. While that bit is 0, the pin is released and the output-2 line goes high.

Top module: `uart_irq_ident`

## Requirements
- R1: While `rst` is high and on the first edges after it, `id_byte` is 8'h01, `irq_out` is 0 and the transmit-empty flag is armed. With `int_en[1]`=1, the first edge after reset reports code 0010.
- R2: `id_byte[3:0]` carries one of six codes: 0110 line error, 0100 receive data, 1100 receive timeout, 0010 transmit empty, 0000 modem change, 0001 nothing pending. `id_byte[5:4]` is 00.
- R3: The ranking from most to least urgent is: line error, then receive data or timeout, then transmit empty, then modem change.
- R4: The enable bits gate the sources. `int_en[0]` gates receive data and timeout, `int_en[1]` gates transmit empty, `int_en[2]` gates line error and `int_en[3]` gates modem change. A disabled source neither shows in the byte nor raises `irq_out`.
- R5: Receive data and receive timeout share a level. When both are present, code 0100 is reported.
- R6: A read (`id_rd`) in a cycle where `id_byte[3:0]` is 0010 clears the transmit-empty flag.
- R7: A read in a cycle where `id_byte[3:0]` shows any other code leaves the transmit-empty flag set. It reappears once the more urgent sources go away.
- R8: A holding-register write (`hold_wr`) clears the transmit-empty flag.
- R9: A `tx_empty_evt` pulse re-arms the transmit-empty flag. In the same cycle it wins over a clearing read or write.
- R10: `id_byte[7:6]` is 11 when `fifo_on` was 1 on the edge that loaded the byte, and 00 otherwise.
- R11: `irq_oe` equals `out2_ctl` and `op2_n` is its inverse. `irq_out` is 0 whenever `out2_ctl` is 0.
- R12: `id_byte` and the interrupt level follow the inputs sampled one clock edge earlier. A change in the transmit-empty flag shows one edge after the flag updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_en | input | 4 | Enables: [0] receive, [1] transmit empty, [2] line error, [3] modem |
| line_err | input | 1 | Receive line error condition (level) |
| rx_ready | input | 1 | Receive data at trigger level (level) |
| rx_timeout | input | 1 | Receive character timeout (level) |
| tx_empty_evt | input | 1 | One-cycle pulse: the holding stage became empty |
| modem_chg | input | 1 | Modem status change pending (level) |
| fifo_on | input | 1 | Queues enabled; sets the top two bits of the byte |
| out2_ctl | input | 1 | Output-2 control bit; enables the interrupt pin |
| id_rd | input | 1 | Identification register read strobe |
| hold_wr | input | 1 | Holding register write strobe |
| id_byte | output | 8 | Identification byte |
| irq_out | output | 1 | Interrupt request value (0 while released) |
| irq_oe | output | 1 | Output enable of the interrupt pin |
| op2_n | output | 1 | Output-2 line, high when the interrupt pin is released |

## Verification
The identification byte and the interrupt level are registered, so they are due one clock edge after the sources, enables and queue mode that produce them. A read or write that clears the transmit-empty flag, or an empty event that sets it, changes the flag on its own edge, and the byte shows the change on the edge after that. The pin gating follows `out2_ctl` without a clock. The bench drives every input 1 ns after a rising edge and samples 1 ns after the next one. Its model steps the flag and the byte with the same one-edge offsets, and it checks the gating outputs in that same window.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int ID_W   = 8;
    localparam int CODE_W = 4;
    localparam int EN_W   = 4;

    typedef enum logic [CODE_W-1:0] {
        CODE_LINE  = 4'b0110,
        CODE_RXD   = 4'b0100,
        CODE_RTO   = 4'b1100,
        CODE_TXE   = 4'b0010,
        CODE_MDM   = 4'b0000,
        CODE_NONE  = 4'b0001
    } irq_code_e;

    // Enable bit order matches the bit positions software writes.
    typedef struct packed {
        logic modem;
        logic line;
        logic txe;
        logic rx;
    } irq_en_t;

    typedef struct packed {
        logic line_err;
        logic rx_ready;
        logic rx_tmo;
        logic txe;
        logic modem;
    } irq_src_t;

    function automatic irq_code_e pick_code(irq_src_t s, irq_en_t e);
        irq_code_e c;
        if (e.line && s.line_err)                     c = CODE_LINE;
        else if (e.rx && s.rx_ready)                  c = CODE_RXD;
        else if (e.rx && s.rx_tmo)                    c = CODE_RTO;
        else if (e.txe && s.txe)                      c = CODE_TXE;
        else if (e.modem && s.modem)                  c = CODE_MDM;
        else                                          c = CODE_NONE;
        return c;
    endfunction

    function automatic logic [ID_W-1:0] build_id(irq_code_e c, logic fifo);
        logic [ID_W-1:0] b;
        b = '0;
        b[CODE_W-1:0]    = c;
        b[ID_W-1:ID_W-2] = {2{fifo}};
        return b;
    endfunction

endpackage

// File: rtl/uart_irq_txe_flag.sv
module uart_irq_txe_flag (
    input  logic clk,
    input  logic rst,
    input  logic empty_evt,
    input  logic hold_wr,
    input  logic id_rd,
    input  logic shown_txe,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b1;
        else if (empty_evt)
            pend <= 1'b1;
        else if (hold_wr || (id_rd && shown_txe))
            pend <= 1'b0;
    end
endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
    import uart_irq_pkg::*;
(
    input  irq_src_t         src,
    input  irq_en_t          en,
    input  logic             fifo,
    output logic [ID_W-1:0]  id_next,
    output logic             any
);
    irq_code_e code;

    always_comb begin
        code    = pick_code(src, en);
        id_next = build_id(code, fifo);
        any     = (en.line  && src.line_err)
                | (en.rx    && (src.rx_ready || src.rx_tmo))
                | (en.txe   && src.txe)
                | (en.modem && src.modem);
    end
endmodule

// File: rtl/uart_irq_pin_gate.sv
module uart_irq_pin_gate (
    input  logic irq_lvl,
    input  logic out2_ctl,
    output logic irq_out,
    output logic irq_oe,
    output logic op2_n
);
    always_comb begin
        irq_oe  = out2_ctl;
        irq_out = out2_ctl & irq_lvl;
        op2_n   = ~out2_ctl;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EN_W-1:0]  int_en,
    input  logic             line_err,
    input  logic             rx_ready,
    input  logic             rx_timeout,
    input  logic             tx_empty_evt,
    input  logic             modem_chg,
    input  logic             fifo_on,
    input  logic             out2_ctl,
    input  logic             id_rd,
    input  logic             hold_wr,
    output logic [ID_W-1:0]  id_byte,
    output logic             irq_out,
    output logic             irq_oe,
    output logic             op2_n
);
    logic            txe_pend;
    logic            shown_txe;
    irq_src_t        src;
    logic [ID_W-1:0] id_next;
    logic            any_next;
    logic [ID_W-1:0] id_q;
    logic            irq_q;

    assign shown_txe = (id_q[CODE_W-1:0] == CODE_TXE);

    uart_irq_txe_flag u_txe (
        .clk       (clk),
        .rst       (rst),
        .empty_evt (tx_empty_evt),
        .hold_wr   (hold_wr),
        .id_rd     (id_rd),
        .shown_txe (shown_txe),
        .pend      (txe_pend)
    );

    always_comb begin
        src.line_err = line_err;
        src.rx_ready = rx_ready;
        src.rx_tmo   = rx_timeout;
        src.txe      = txe_pend;
        src.modem    = modem_chg;
    end

    uart_irq_prio_enc u_enc (
        .src     (src),
        .en      (irq_en_t'(int_en)),
        .fifo    (fifo_on),
        .id_next (id_next),
        .any     (any_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q  <= build_id(CODE_NONE, 1'b0);
            irq_q <= 1'b0;
        end else begin
            id_q  <= id_next;
            irq_q <= any_next;
        end
    end

    assign id_byte = id_q;

    uart_irq_pin_gate u_gate (
        .irq_lvl  (irq_q),
        .out2_ctl (out2_ctl),
        .irq_out  (irq_out),
        .irq_oe   (irq_oe),
        .op2_n    (op2_n)
    );
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst,
    input logic       fifo_on,
    input logic       out2_ctl,
    input logic       id_rd,
    input logic       hold_wr,
    input logic       tx_empty_evt,
    input logic       txe_pend,
    input logic [7:0] id_byte,
    input logic       irq_out,
    input logic       irq_oe,
    input logic       op2_n
);
    // R2: no-pending code has clear upper code bits and reserved bits
    a_r2_none_code: assert property (@(posedge clk) disable iff (rst)
        id_byte[0] |-> (id_byte[5:1] == 5'b0));

    // R11: pin released and output-2 high while control bit is 0
    a_r11_pin_gate: assert property (@(posedge clk) disable iff (rst)
        !out2_ctl |-> (!irq_out && !irq_oe && op2_n));

    // R11: when driven, pin agrees with the identification byte
    a_r11_irq_agrees: assert property (@(posedge clk) disable iff (rst)
        out2_ctl |-> (irq_out == !id_byte[0]));

    // R6: read that shows transmit-empty clears the flag
    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (id_rd && id_byte[3:0] == 4'b0010 && !tx_empty_evt) |=> !txe_pend);

    // R7: read showing another code leaves the flag alone
    a_r7_read_keeps: assert property (@(posedge clk) disable iff (rst)
        (txe_pend && id_rd && id_byte[3:0] != 4'b0010 && !hold_wr) |=> txe_pend);

    // R8: holding write clears the flag
    a_r8_write_clears: assert property (@(posedge clk) disable iff (rst)
        (hold_wr && !tx_empty_evt) |=> !txe_pend);

    // R9: empty event always re-arms
    a_r9_rearm: assert property (@(posedge clk) disable iff (rst)
        tx_empty_evt |=> txe_pend);

    // R10: top bits follow the queue mode of the loading edge
    a_r10_fifo_bits: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (id_byte[7:6] == {2{$past(fifo_on)}}));
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .fifo_on      (fifo_on),
    .out2_ctl     (out2_ctl),
    .id_rd        (id_rd),
    .hold_wr      (hold_wr),
    .tx_empty_evt (tx_empty_evt),
    .txe_pend     (txe_pend),
    .id_byte      (id_byte),
    .irq_out      (irq_out),
    .irq_oe       (irq_oe),
    .op2_n        (op2_n)
);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] int_en;
    logic       line_err, rx_ready, rx_timeout, tx_empty_evt, modem_chg;
    logic       fifo_on, out2_ctl, id_rd, hold_wr;
    logic [7:0] id_byte;
    logic       irq_out, irq_oe, op2_n;

    int checks = 0;
    int fails  = 0;

    logic [7:0] exp_id;
    logic       exp_irq;
    logic       m_txe;

    always #2 clk = ~clk;

    uart_irq_ident dut (
        .clk(clk), .rst(rst), .int_en(int_en), .line_err(line_err),
        .rx_ready(rx_ready), .rx_timeout(rx_timeout),
        .tx_empty_evt(tx_empty_evt), .modem_chg(modem_chg),
        .fifo_on(fifo_on), .out2_ctl(out2_ctl), .id_rd(id_rd),
        .hold_wr(hold_wr), .id_byte(id_byte), .irq_out(irq_out),
        .irq_oe(irq_oe), .op2_n(op2_n)
    );

    function automatic logic [7:0] enc(logic [3:0] en, logic le, logic rd,
                                       logic to, logic tx, logic md, logic fe);
        logic [3:0] c;
        if (en[2] && le)            c = 4'b0110;
        else if (en[0] && rd)       c = 4'b0100;
        else if (en[0] && to)       c = 4'b1100;
        else if (en[1] && tx)       c = 4'b0010;
        else if (en[3] && md)       c = 4'b0000;
        else                        c = 4'b0001;
        return {{2{fe}}, 2'b00, c};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        int_en = 4'h0; line_err = 0; rx_ready = 0; rx_timeout = 0;
        tx_empty_evt = 0; modem_chg = 0; id_rd = 0; hold_wr = 0;
    endtask

    // One clock edge: step the model, then compare 1 ns later.
    task automatic tick(input string tag);
        logic [7:0] nid;
        logic       nirq;
        @(posedge clk);
        if (rst) begin
            exp_id = 8'h01; exp_irq = 1'b0; m_txe = 1'b1;
        end else begin
            nid  = enc(int_en, line_err, rx_ready, rx_timeout, m_txe, modem_chg, fifo_on);
            nirq = !nid[0];
            if (tx_empty_evt) m_txe = 1'b1;
            else if (hold_wr || (id_rd && exp_id[3:0] == 4'b0010)) m_txe = 1'b0;
            exp_id = nid; exp_irq = nirq;
        end
        #1;
        chk({tag, " id"}, id_byte, exp_id);
        chk({tag, " irq"}, {7'b0, irq_out}, {7'b0, out2_ctl & exp_irq});
        chk("R11 oe", {7'b0, irq_oe}, {7'b0, out2_ctl});
        chk("R11 op2", {7'b0, op2_n}, {7'b0, ~out2_ctl});
        idle_strobes();
    endtask

    task automatic idle_strobes();
        id_rd = 0; hold_wr = 0; tx_empty_evt = 0;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd5150);
        idle(); fifo_on = 0; out2_ctl = 1; rst = 1;
        exp_id = 8'h01; exp_irq = 0; m_txe = 1;
        #1;
        tick("R1"); tick("R1");
        chk("R1 reset id", id_byte, 8'h01);
        chk("R1 reset irq", {7'b0, irq_out}, 8'h00);

        // R1: transmit-empty armed out of reset
        int_en = 4'b0010; rst = 0;
        tick("R1");
        chk("R1 txe after reset", id_byte, 8'h02);

        // R6: read showing 0010 clears
        id_rd = 1; tick("R6"); tick("R6");
        chk("R6 cleared", id_byte, 8'h01);

        // R9 re-arm, R7 masked read keeps flag
        tx_empty_evt = 1; tick("R9"); tick("R9");
        chk("R9 rearmed", id_byte, 8'h02);
        int_en = 4'b0110; line_err = 1; tick("R3");
        chk("R3 line over txe", id_byte, 8'h06);
        id_rd = 1; tick("R7"); id_rd = 1; tick("R7");
        line_err = 0; tick("R7"); tick("R7");
        chk("R7 txe survives", id_byte, 8'h02);

        // R8 holding write clears
        hold_wr = 1; tick("R8"); tick("R8");
        chk("R8 write cleared", id_byte, 8'h01);

        // R9 event wins over write and read in the same cycle
        tx_empty_evt = 1; tick("R9");
        tx_empty_evt = 1; hold_wr = 1; id_rd = 1; tick("R9"); tick("R9");
        chk("R9 event wins", id_byte, 8'h02);

        // R5 shared level
        int_en = 4'b0001; rx_ready = 1; rx_timeout = 1; tick("R5");
        chk("R5 data over timeout", id_byte, 8'h04);
        rx_ready = 0; tick("R5");
        chk("R5 timeout", id_byte, 8'h0C);

        // R4 all sources, nothing enabled
        line_err = 1; rx_ready = 1; modem_chg = 1; int_en = 4'b0000; tick("R4");
        chk("R4 gated", id_byte, 8'h01);
        chk("R4 no irq", {7'b0, irq_out}, 8'h00);

        // R3 ranking walk
        int_en = 4'b1111; tick("R3");
        chk("R3 line first", id_byte, 8'h06);
        line_err = 0; tick("R3");
        chk("R3 rx second", id_byte, 8'h04);
        rx_ready = 0; rx_timeout = 0; tick("R3");
        chk("R3 txe third", id_byte, 8'h02);
        id_rd = 1; tick("R3"); tick("R3");
        chk("R3 modem last", id_byte, 8'h00);
        chk("R2 modem irq", {7'b0, irq_out}, 8'h01);

        // R10 queue bits
        fifo_on = 1; tick("R10");
        chk("R10 fifo bits", id_byte, 8'hC0);

        // R11 pin released
        out2_ctl = 0; #1;
        chk("R11 released out", {7'b0, irq_out}, 8'h00);
        chk("R11 released op2", {7'b0, op2_n}, 8'h01);
        tick("R11");
        out2_ctl = 1;

        // R12/R2: random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int_en       = 4'($urandom);
            line_err     = ($urandom % 6) == 0;
            rx_ready     = ($urandom % 4) == 0;
            rx_timeout   = ($urandom % 5) == 0;
            modem_chg    = ($urandom % 3) == 0;
            tx_empty_evt = ($urandom % 7) == 0;
            id_rd        = ($urandom % 3) == 0;
            hold_wr      = ($urandom % 9) == 0;
            fifo_on      = ($urandom % 2) == 0;
            out2_ctl     = ($urandom % 8) != 0;
            tick("R12");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule